// File: doc/BRIEF.md
# IDE Hidden Configuration Unlock Sequencer

This block sits on the device side of a legacy IDE channel and watches every host bus cycle on the task-file addresses. A bank of configuration registers stays hidden behind those addresses until the host performs an ordered access pattern. The pattern is two 16-bit reads of task-file register 1 in a row, followed by a byte write of an unlock key to task-file register 2. Any other access part way through the pattern abandons it. That access is then treated as an ordinary task-file access.

Once the bank is open, every byte-wide access at task-file offset N is steered to hidden register N. Read data is returned from the register file instead of the task file. 16-bit accesses still go to the task file. The bank holds per-drive read and write cycle timing, a channel enable control, a read-only speed strap, and a miscellaneous register with drive select, delay, address setup and prefetch fields. A byte write of a relock key to offset 2 closes the bank and restores normal task-file decode.

Top module: `ide_cfg_unlock`

## Requirements
- R1: After reset the bank is locked and the channel is disabled (control reads 0x11). Both timing registers of both drives are zero, and the miscellaneous register is zero.
- R2: The bank opens on the clock edge that follows this exact sequence of cycles: a 16-bit read of offset 1, another 16-bit read of offset 1, then an 8-bit write of 0x03 to offset 2. The unlock write itself is a task-file access.
- R3: While locked, each access is a task-file access: cfg_hit_o is 0 and rdata_o equals tf_rdata_i. Within the pattern, the following accesses send the sequencer back to the start: a write, a byte access, another offset, a third 16-bit read of offset 1, or a write of a value other than 0x03.
- R4: While open, a byte access (bus_wide_i=0) is a configuration access: cfg_hit_o is 1 and rdata_o is {8'h00, hidden register at bus_addr_i}. A 16-bit access is still a task-file access.
- R5: While open, a byte write of 0x83 to offset 2 locks the bank from the next edge on.
- R6: Offset 0 is read cycle timing and offset 1 is write cycle timing. In each, bits 3:0 are recovery and bits 7:4 are pulse width. Both are exported per drive, with drive d at bits 8d+7:8d.
- R7: The timing registers are banked per drive. Miscellaneous bit 0 selects the drive copy that is read or written at offsets 0 and 1, and the other copy is left unchanged.
- R8: Control is at offset 3. Writing 0x95 enables the channel and writing 0x11 disables it. Any other value leaves it unchanged. It reads back as 0x95 or 0x11.
- R9: Strap is at offset 5. It reads {7'b0, strap_slow_i}, where 0 means a 33 MHz bus and 1 means a 25 MHz bus, and writes to it have no effect.
- R10: Miscellaneous is at offset 6 and is stored as written data AND 0x7F. Bit 0 is the drive select, bits 3:1 the delay, bits 5:4 the address setup, and bit 6 the read prefetch enable.
- R11: While open, offsets 2, 4 and 7 read as zero. A write to them stores nothing, apart from the relock write of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | A host cycle is present this clock |
| bus_addr_i | input | 3 | Task-file offset |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_wide_i | input | 1 | 1 = 16-bit cycle, 0 = 8-bit cycle |
| bus_wdata_i | input | 8 | Write data, low byte |
| tf_rdata_i | input | 16 | Read data from the normal task file |
| strap_slow_i | input | 1 | Bus speed strap, 1 = 25 MHz |
| rdata_o | output | 16 | Steered read data |
| cfg_hit_o | output | 1 | Current cycle targets the hidden bank |
| unlocked_o | output | 1 | Hidden bank is open |
| chan_en_o | output | 1 | Channel enabled |
| rd_tim_o | output | 16 | Read timing per drive |
| wr_tim_o | output | 16 | Write timing per drive |
| drv_sel_o | output | 1 | Drive select |
| delay_o | output | 3 | Delay field |
| setup_o | output | 2 | Address setup field |
| prefetch_o | output | 1 | Read prefetch enable |

## Verification
The bench builds the block with its default keys (0x03 to unlock, 0x83 to relock) and two drives. With two drives, flipping miscellaneous bit 0 shows whether a timing write leaked into the copy that was not selected. Random cycles use a narrow address range and mostly byte widths. Unlock patterns are injected often enough that partial patterns, third reads and wrong keys hit every state of the sequencer. They also make the random writes reach the control, strap and reserved offsets while the bank is open.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;
  localparam int N_DRIVES = 2;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] OFS_RD_TIM = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_WR_TIM = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_STRAP  = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MISC   = 3'd6;

  localparam logic [7:0] CTRL_ON   = 8'h95;
  localparam logic [7:0] CTRL_OFF  = 8'h11;
  localparam logic [7:0] MISC_MASK = 8'h7F;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ONE  = 2'd1,
    SQ_TWO  = 2'd2,
    SQ_OPEN = 2'd3
  } seq_state_e;
endpackage

// File: rtl/ide_unlock_fsm.sv
module ide_unlock_fsm
  import ide_cfg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PROBE_ADDR = 3'd1,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 3'd2,
  parameter logic [7:0]        UNLOCK_KEY = 8'h03,
  parameter logic [7:0]        RELOCK_KEY = 8'h83
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              wide_i,
  input  logic [7:0]        wdata_i,
  output logic              unlocked_o
);
  seq_state_e state_q, state_d;

  logic probe_rd, key_wr, relock_wr;
  assign probe_rd  = !we_i && wide_i && (addr_i == PROBE_ADDR);
  assign key_wr    = we_i && !wide_i && (addr_i == KEY_ADDR) && (wdata_i == UNLOCK_KEY);
  assign relock_wr = we_i && !wide_i && (addr_i == KEY_ADDR) && (wdata_i == RELOCK_KEY);

  always_comb begin
    state_d = state_q;
    if (valid_i) begin
      unique case (state_q)
        SQ_IDLE: state_d = probe_rd ? SQ_ONE  : SQ_IDLE;
        SQ_ONE:  state_d = probe_rd ? SQ_TWO  : SQ_IDLE;
        SQ_TWO:  state_d = key_wr   ? SQ_OPEN : SQ_IDLE;
        SQ_OPEN: state_d = relock_wr ? SQ_IDLE : SQ_OPEN;
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SQ_IDLE;
    else         state_q <= state_d;
  end

  assign unlocked_o = (state_q == SQ_OPEN);

  a_r2_open_needs_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $past(valid_i && we_i && !wide_i && addr_i == KEY_ADDR
                                && wdata_i == UNLOCK_KEY));
  a_r5_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && valid_i && we_i && !wide_i && addr_i == KEY_ADDR
     && wdata_i == RELOCK_KEY) |=> !unlocked_o);
  a_r3_idle_stays_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && !valid_i) |=> !unlocked_o);
endmodule

// File: rtl/ide_tim_bank.sv
module ide_tim_bank (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_we_i,
  input  logic       wr_we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rd_tim_o,
  output logic [7:0] wr_tim_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_tim_o <= '0;
      wr_tim_o <= '0;
    end else begin
      if (rd_we_i) rd_tim_o <= wdata_i;
      if (wr_we_i) wr_tim_o <= wdata_i;
    end
  end

  a_r7_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_we_i |=> $stable(rd_tim_o));
  a_r7_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_we_i |=> $stable(wr_tim_o));
endmodule

// File: rtl/ide_cfg_regfile.sv
module ide_cfg_regfile
  import ide_cfg_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [7:0]            wdata_i,
  input  logic                  strap_slow_i,
  output logic [7:0]            rdata_o,
  output logic                  chan_en_o,
  output logic [N_DRIVES*8-1:0] rd_tim_o,
  output logic [N_DRIVES*8-1:0] wr_tim_o,
  output logic [7:0]            misc_o
);
  localparam int SEL_W = $clog2(N_DRIVES);

  logic [7:0]       misc_q;
  logic             en_q;
  logic [SEL_W-1:0] sel;
  logic [7:0]       rd_tim [N_DRIVES];
  logic [7:0]       wr_tim [N_DRIVES];

  assign sel = misc_q[SEL_W-1:0];

  for (genvar d = 0; d < N_DRIVES; d++) begin : g_bank
    logic hit;
    assign hit = wr_en_i && (sel == SEL_W'(d));
    ide_tim_bank u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rd_we_i  (hit && addr_i == OFS_RD_TIM),
      .wr_we_i  (hit && addr_i == OFS_WR_TIM),
      .wdata_i  (wdata_i),
      .rd_tim_o (rd_tim[d]),
      .wr_tim_o (wr_tim[d])
    );
    assign rd_tim_o[d*8 +: 8] = rd_tim[d];
    assign wr_tim_o[d*8 +: 8] = wr_tim[d];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      misc_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == OFS_MISC) misc_q <= wdata_i & MISC_MASK;
      if (addr_i == OFS_CTRL) begin
        if (wdata_i == CTRL_ON)       en_q <= 1'b1;
        else if (wdata_i == CTRL_OFF) en_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_RD_TIM: rdata_o = rd_tim[sel];
      OFS_WR_TIM: rdata_o = wr_tim[sel];
      OFS_CTRL:   rdata_o = en_q ? CTRL_ON : CTRL_OFF;
      OFS_STRAP:  rdata_o = {7'b0, strap_slow_i};
      OFS_MISC:   rdata_o = misc_q;
      default:    rdata_o = 8'h00;
    endcase
  end

  assign chan_en_o = en_q;
  assign misc_o    = misc_q;

  a_r10_bit7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !misc_o[7]);
  a_r8_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == OFS_CTRL) |=> $stable(chan_en_o));
  a_r7_other_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_RD_TIM && !misc_o[0]) |=> $stable(rd_tim_o[15:8]));
endmodule

// File: rtl/ide_cfg_unlock.sv
module ide_cfg_unlock
  import ide_cfg_pkg::*;
#(
  parameter logic [7:0] UNLOCK_KEY = 8'h03,
  parameter logic [7:0] RELOCK_KEY = 8'h83
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_valid_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic                  bus_we_i,
  input  logic                  bus_wide_i,
  input  logic [7:0]            bus_wdata_i,
  input  logic [15:0]           tf_rdata_i,
  input  logic                  strap_slow_i,
  output logic [15:0]           rdata_o,
  output logic                  cfg_hit_o,
  output logic                  unlocked_o,
  output logic                  chan_en_o,
  output logic [N_DRIVES*8-1:0] rd_tim_o,
  output logic [N_DRIVES*8-1:0] wr_tim_o,
  output logic                  drv_sel_o,
  output logic [2:0]            delay_o,
  output logic [1:0]            setup_o,
  output logic                  prefetch_o
);
  logic [7:0] cfg_rdata, misc;

  ide_unlock_fsm #(
    .UNLOCK_KEY (UNLOCK_KEY),
    .RELOCK_KEY (RELOCK_KEY)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (bus_valid_i),
    .addr_i     (bus_addr_i),
    .we_i       (bus_we_i),
    .wide_i     (bus_wide_i),
    .wdata_i    (bus_wdata_i),
    .unlocked_o (unlocked_o)
  );

  assign cfg_hit_o = bus_valid_i && unlocked_o && !bus_wide_i;

  ide_cfg_regfile u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (cfg_hit_o && bus_we_i),
    .addr_i       (bus_addr_i),
    .wdata_i      (bus_wdata_i),
    .strap_slow_i (strap_slow_i),
    .rdata_o      (cfg_rdata),
    .chan_en_o    (chan_en_o),
    .rd_tim_o     (rd_tim_o),
    .wr_tim_o     (wr_tim_o),
    .misc_o       (misc)
  );

  assign rdata_o    = cfg_hit_o ? {8'h00, cfg_rdata} : tf_rdata_i;
  assign drv_sel_o  = misc[0];
  assign delay_o    = misc[3:1];
  assign setup_o    = misc[5:4];
  assign prefetch_o = misc[6];

  a_r4_wide_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && bus_wide_i) |-> (rdata_o == tf_rdata_i));
  a_r3_locked_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_o |-> (rdata_o == tf_rdata_i));
endmodule

// File: tb/ide_cfg_unlock_bench.sv
module ide_cfg_unlock_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic        wide = 1'b0;
  logic [7:0]  wdata = '0;
  logic [15:0] tf_rdata = '0;
  logic        strap = 1'b0;
  logic [15:0] rdata;
  logic        cfg_hit, unlocked, chan_en, drv_sel, prefetch;
  logic [15:0] rd_tim, wr_tim;
  logic [2:0]  delay;
  logic [1:0]  setup;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  int         m_seq = 0;  // 0 idle, 1 one read, 2 two reads, 3 open
  logic [7:0] m_rt [2];
  logic [7:0] m_wt [2];
  logic       m_en;
  logic [7:0] m_misc;

  always #4 clk = ~clk;

  ide_cfg_unlock u_ide_cfg_unlock (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wide_i(wide), .bus_wdata_i(wdata), .tf_rdata_i(tf_rdata),
    .strap_slow_i(strap), .rdata_o(rdata), .cfg_hit_o(cfg_hit),
    .unlocked_o(unlocked), .chan_en_o(chan_en), .rd_tim_o(rd_tim),
    .wr_tim_o(wr_tim), .drv_sel_o(drv_sel), .delay_o(delay), .setup_o(setup),
    .prefetch_o(prefetch)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return m_rt[m_misc[0]];
      3'd1: return m_wt[m_misc[0]];
      3'd3: return m_en ? 8'h95 : 8'h11;
      3'd5: return {7'b0, strap};
      3'd6: return m_misc;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string read_tag(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R7";
      3'd3: return "R8";
      3'd5: return "R9";
      3'd6: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic model_step(input logic [2:0] a, input logic w, input logic wd16,
                            input logic [7:0] d);
    bit probe, key;
    probe = !w && wd16 && a == 3'd1;
    key   = w && !wd16 && a == 3'd2 && d == 8'h03;
    case (m_seq)
      0: m_seq = probe ? 1 : 0;
      1: m_seq = probe ? 2 : 0;
      2: m_seq = key ? 3 : 0;
      default: begin
        if (w && !wd16) begin
          case (a)
            3'd0: m_rt[m_misc[0]] = d;
            3'd1: m_wt[m_misc[0]] = d;
            3'd2: if (d == 8'h83) m_seq = 0;
            3'd3: if (d == 8'h95) m_en = 1'b1; else if (d == 8'h11) m_en = 1'b0;
            3'd6: m_misc = d & 8'h7F;
            default: ;
          endcase
        end
      end
    endcase
  endtask

  task automatic check_state(input string tag);
    check(unlocked == (m_seq == 3), tag, {15'b0, unlocked}, {15'b0, m_seq == 3});
    check(chan_en == m_en, "R8", {15'b0, chan_en}, {15'b0, m_en});
    check(rd_tim == {m_rt[1], m_rt[0]}, "R6", rd_tim, {m_rt[1], m_rt[0]});
    check(wr_tim == {m_wt[1], m_wt[0]}, "R6", wr_tim, {m_wt[1], m_wt[0]});
    check({prefetch, setup, delay, drv_sel} == m_misc[6:0], "R10",
          {9'b0, prefetch, setup, delay, drv_sel}, {9'b0, m_misc[6:0]});
  endtask

  task automatic acc(input logic [2:0] a, input logic w, input logic wd16,
                     input logic [7:0] d);
    bit exp_hit;
    logic [15:0] exp_rd;
    string tag;
    @(negedge clk);
    valid = 1'b1; addr = a; we = w; wide = wd16; wdata = d;
    tf_rdata = 16'($urandom);
    #1;
    exp_hit = (m_seq == 3) && !wd16;
    exp_rd  = exp_hit ? {8'h00, model_read(a)} : tf_rdata;
    tag     = exp_hit ? read_tag(a) : ((m_seq == 3) ? "R4" : "R3");
    check(cfg_hit == exp_hit, exp_hit ? "R4" : "R3", {15'b0, cfg_hit}, {15'b0, exp_hit});
    check(rdata == exp_rd, tag, rdata, exp_rd);
    model_step(a, w, wd16, d);
    @(posedge clk);
    #1;
    valid = 1'b0;
    check_state((m_seq == 3) ? "R2" : "R5");
  endtask

  task automatic unlock_seq();
    acc(3'd1, 1'b0, 1'b1, 8'h00);
    acc(3'd1, 1'b0, 1'b1, 8'h00);
    acc(3'd2, 1'b1, 1'b0, 8'h03);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1DE5EED));
    m_rt[0] = '0; m_rt[1] = '0; m_wt[0] = '0; m_wt[1] = '0;
    m_en = 1'b0; m_misc = '0; m_seq = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!unlocked, "R1", {15'b0, unlocked}, 16'h0);
    check(!chan_en, "R1", {15'b0, chan_en}, 16'h0);
    check(rd_tim == 16'h0 && wr_tim == 16'h0, "R1", rd_tim | wr_tim, 16'h0);
    check({prefetch, setup, delay, drv_sel} == 7'h0, "R1",
          {9'b0, prefetch, setup, delay, drv_sel}, 16'h0);

    // R3: broken patterns
    acc(3'd1, 1'b0, 1'b1, 8'h00); acc(3'd1, 1'b0, 1'b0, 8'h00);  // byte read
    acc(3'd2, 1'b1, 1'b0, 8'h03);
    check(!unlocked, "R3", {15'b0, unlocked}, 16'h0);
    acc(3'd1, 1'b0, 1'b1, 8'h00); acc(3'd1, 1'b0, 1'b1, 8'h00);
    acc(3'd1, 1'b0, 1'b1, 8'h00); acc(3'd2, 1'b1, 1'b0, 8'h03);   // third read
    check(!unlocked, "R3", {15'b0, unlocked}, 16'h0);
    acc(3'd1, 1'b0, 1'b1, 8'h00); acc(3'd1, 1'b0, 1'b1, 8'h00);
    acc(3'd2, 1'b1, 1'b0, 8'h04);                                  // wrong key
    acc(3'd1, 1'b0, 1'b1, 8'h00); acc(3'd3, 1'b0, 1'b1, 8'h00);   // other addr
    acc(3'd1, 1'b0, 1'b1, 8'h00); acc(3'd2, 1'b1, 1'b0, 8'h03);

    // R2 and R1 readback
    unlock_seq();
    check(unlocked, "R2", {15'b0, unlocked}, 16'h1);
    for (int a = 0; a < 8; a++) acc(3'(a), 1'b0, 1'b0, 8'h00);
    acc(3'd1, 1'b0, 1'b1, 8'h00);                                  // R4 wide passes

    // R6 R7 banks
    acc(3'd0, 1'b1, 1'b0, 8'hA5); acc(3'd1, 1'b1, 1'b0, 8'h3C);
    acc(3'd6, 1'b1, 1'b0, 8'h01);
    acc(3'd0, 1'b0, 1'b0, 8'h00);
    acc(3'd0, 1'b1, 1'b0, 8'h5A); acc(3'd1, 1'b1, 1'b0, 8'hC3);
    acc(3'd6, 1'b1, 1'b0, 8'h00); acc(3'd0, 1'b0, 1'b0, 8'h00);
    // R8
    acc(3'd3, 1'b1, 1'b0, 8'h95); acc(3'd3, 1'b1, 1'b0, 8'h42);
    acc(3'd3, 1'b0, 1'b0, 8'h00); acc(3'd3, 1'b1, 1'b0, 8'h11);
    acc(3'd3, 1'b1, 1'b0, 8'h95);
    // R9
    strap = 1'b1; acc(3'd5, 1'b0, 1'b0, 8'h00);
    acc(3'd5, 1'b1, 1'b0, 8'hFE); acc(3'd5, 1'b0, 1'b0, 8'h00);
    strap = 1'b0; acc(3'd5, 1'b0, 1'b0, 8'h00);
    // R10 R11
    acc(3'd6, 1'b1, 1'b0, 8'hFE); acc(3'd6, 1'b0, 1'b0, 8'h00);
    acc(3'd4, 1'b1, 1'b0, 8'hFF); acc(3'd4, 1'b0, 1'b0, 8'h00);
    acc(3'd7, 1'b1, 1'b0, 8'hFF); acc(3'd2, 1'b1, 1'b0, 8'h55);
    check(unlocked, "R11", {15'b0, unlocked}, 16'h1);
    // R5
    acc(3'd2, 1'b1, 1'b0, 8'h83);
    check(!unlocked, "R5", {15'b0, unlocked}, 16'h0);
    acc(3'd0, 1'b1, 1'b0, 8'h77);  // locked: task-file only

    // random
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 15));
      strap = 1'($urandom);
      if (r == 0) unlock_seq();
      else if (r == 1) begin
        acc(3'd1, 1'b0, 1'b1, 8'h00); acc(3'd1, 1'b0, 1'b1, 8'h00);
      end else begin
        logic [7:0] d;
        d = ($urandom_range(0, 7) == 0) ? 8'h83 :
            ($urandom_range(0, 5) == 0) ? 8'h95 : 8'($urandom);
        acc(3'($urandom), 1'($urandom), ($urandom_range(0, 4) == 0), d);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule